// File: doc/BRIEF.md
# FM Phase Generator

This block produces the phase that addresses a wavetable oscillator in a digital synthesizer, with frequency modulation already applied. A 24-bit carrier phase register advances by a tuning word on every enabled clock. Each clock, a signed modulation sample is multiplied by an unsigned modulation index. The product is scaled down by 256 and added to the carrier phase. The sum is the modulated phase, and it leaves the block through an output register.

The modulation offset only affects the output. It never enters the carrier phase register, so the carrier frequency does not depend on the modulation. Software or upstream logic sets the tuning word for the note. A modulator oscillator feeds the modulation sample, and an envelope or control value sets the index. The output goes straight to the wavetable address.

Top module: `fm_phase_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the carrier phase and phase_o are both cleared to zero at that edge (synchronous, active-low).
- R2: At each rising edge where en_i is high and reset is inactive, the carrier phase becomes its previous value plus tune_i, modulo 2^24 (the carry out of bit 23 is dropped).
- R3: At a rising edge where en_i is low, the carrier phase keeps its value, and phase_o still updates from the held phase and the current modulation.
- R4: The modulation offset is floor(M * S / 256), reduced modulo 2^24. M is mod_i read as a 24-bit two's complement number (bit 23 is the sign). S is scale_i read as an 8-bit unsigned number.
- R5: phase_o after a rising edge equals the carrier phase held before that edge plus the offset of the mod_i and scale_i sampled at that edge, modulo 2^24 (one register of latency).
- R6: The modulation never changes the carrier phase. Once mod_i returns to zero, phase_o equals the phase of a carrier that was never modulated.
- R7: When mod_i or scale_i is zero, phase_o is exactly the carrier phase from the previous cycle.
- R8: A negative offset larger than the carrier phase wraps modulo 2^24. It does not saturate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Carrier phase advance enable |
| tune_i | input | 24 | Carrier tuning word (phase step per clock) |
| mod_i | input | 24 | Modulation sample, two's complement |
| scale_i | input | 8 | Modulation index, unsigned |
| phase_o | output | 24 | Registered modulated phase |

## Verification
The bench targets rounding of negative products. A design that truncated toward zero instead of flooring would output 0 instead of 0xFFFFFF for mod_i = -1 with index 1. The extreme products at full-scale positive and negative samples with index 255 expose a design that reads the index as signed or the sample as unsigned. Wrap of both the carrier and the sum below zero is driven, and a saturating design would stick at an end value. Disabling the carrier while modulation continues, and removing modulation after a long modulated run, would show a design that folded the offset into the stored phase or froze the output while disabled.

// File: rtl/fm_phase_pkg.sv
// Package: default widths shared by the FM phase generator and its bench.
// Assumes all users take their widths from these defaults unless overridden.
package fm_phase_pkg;
    localparam int unsigned PHASE_W_DEF = 24;
    localparam int unsigned MOD_W_DEF   = 24;
    localparam int unsigned SCALE_W_DEF = 8;
    localparam int unsigned SHIFT_DEF   = 8;
endpackage

// File: rtl/fm_carrier_acc.sv
// Carrier phase register: adds the tuning word on each enabled clock and
// wraps modulo 2^PHASE_W. Assumes a synchronous active-low reset.
module fm_carrier_acc #(
    parameter int unsigned PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] tune_i,
    output logic [PHASE_W-1:0] acc_o
);
    logic [PHASE_W-1:0] acc_q;

    // Purpose: step or hold the carrier phase; the carry out is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en_i)
            acc_q <= acc_q + tune_i;
    end

    assign acc_o = acc_q;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> acc_q == $past(acc_q + tune_i));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q));
endmodule

// File: rtl/fm_mod_scale.sv
// Modulation scaler: signed sample times unsigned index, arithmetic right
// shift (floor), result cut or sign-extended to PHASE_W. Combinational.
module fm_mod_scale #(
    parameter int unsigned PHASE_W = 24,
    parameter int unsigned MOD_W   = 24,
    parameter int unsigned SCALE_W = 8,
    parameter int unsigned SHIFT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MOD_W-1:0]   mod_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [PHASE_W-1:0] offset_o
);
    localparam int unsigned PROD_W = MOD_W + SCALE_W + 1;

    logic signed [PROD_W-1:0] mod_ext;
    logic signed [PROD_W-1:0] scl_ext;
    logic signed [PROD_W-1:0] prod;

    // Purpose: widen both operands to the product width, then multiply.
    always_comb begin
        mod_ext = PROD_W'($signed(mod_i));
        scl_ext = PROD_W'($signed({1'b0, scale_i}));
        prod    = mod_ext * scl_ext;
    end

    generate
        if (SHIFT == 0) begin : g_noshift
            assign offset_o = PHASE_W'(prod);
        end else begin : g_shift
            assign offset_o = PHASE_W'(prod >>> SHIFT);
        end
    endgenerate

    assert_zero_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_i == '0) |-> (offset_o == '0));
endmodule

// File: rtl/fm_phase_sum.sv
// Output stage: adds the offset to the carrier phase modulo 2^PHASE_W and
// registers the result. Assumes a synchronous active-low reset.
module fm_phase_sum #(
    parameter int unsigned PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] acc_i,
    input  logic [PHASE_W-1:0] offset_i,
    output logic [PHASE_W-1:0] phase_o
);
    // Purpose: register the wrapped sum of carrier phase and offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_o <= '0;
        else
            phase_o <= acc_i + offset_i;
    end
endmodule

// File: rtl/fm_phase_gen.sv
// Top: FM phase generator. The carrier register steps by the tuning word;
// the scaled modulation is added only on the output path, so the carrier
// frequency is independent of the modulation. One cycle of output latency.
module fm_phase_gen
    import fm_phase_pkg::*;
#(
    parameter int unsigned PHASE_W = PHASE_W_DEF,
    parameter int unsigned MOD_W   = MOD_W_DEF,
    parameter int unsigned SCALE_W = SCALE_W_DEF,
    parameter int unsigned SHIFT   = SHIFT_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] tune_i,
    input  logic [MOD_W-1:0]   mod_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [PHASE_W-1:0] phase_o
);
    logic [PHASE_W-1:0] acc;
    logic [PHASE_W-1:0] offset;

    fm_carrier_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tune_i(tune_i), .acc_o(acc)
    );

    fm_mod_scale #(
        .PHASE_W(PHASE_W), .MOD_W(MOD_W), .SCALE_W(SCALE_W), .SHIFT(SHIFT)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .mod_i(mod_i), .scale_i(scale_i),
        .offset_o(offset)
    );

    fm_phase_sum #(.PHASE_W(PHASE_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .offset_i(offset),
        .phase_o(phase_o)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && acc == '0));

    assert_bare_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_i == '0 || scale_i == '0) |=> phase_o == $past(acc));
endmodule

// File: tb/tb_fm_phase_gen.sv
// Bench: behavioural per-clock reference model compared on every clock.
module tb_fm_phase_gen;
    localparam longint MASK = 64'hFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [23:0] tune_i = '0;
    logic [23:0] mod_i = '0;
    logic [7:0]  scale_i = '0;
    logic [23:0] phase_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string req = "R1";
    longint m_acc = 0;
    longint m_out = 0;

    fm_phase_gen dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tune_i(tune_i),
        .mod_i(mod_i), .scale_i(scale_i), .phase_o(phase_o)
    );

    always #4 clk = ~clk;

    function automatic longint offs(input logic [23:0] m, input logic [7:0] s);
        longint mv = longint'(m);
        longint p;
        if (mv >= 64'd8388608) mv = mv - 64'd16777216;
        p = mv * longint'(s);
        p = p >>> 8;
        return p & MASK;
    endfunction

    // Reference model updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0;
            m_out = 0;
        end else begin
            m_out = (m_acc + offs(mod_i, scale_i)) & MASK;
            if (en_i) m_acc = (m_acc + longint'(tune_i)) & MASK;
        end
    end

    task automatic chk(input string r, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: phase_o=%06h expected=%06h", r, got, exp);
        end
    endtask

    // One clock: wait for the falling edge, compare against the model.
    task automatic tick();
        @(negedge clk);
        chk(req, longint'(phase_o), m_out);
    endtask

    task automatic drive(input bit e, input logic [23:0] t,
                         input logic [23:0] m, input logic [7:0] s);
        en_i = e; tune_i = t; mod_i = m; scale_i = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs clears everything.
        req = "R1";
        drive(1'b1, 24'h00ABCD, 24'h123456, 8'hFF);
        repeat (3) tick();
        chk("R1", longint'(phase_o), 0);
        rst_n = 1'b1;

        // R4/R8: fixed offsets from a zero carrier with the carrier held.
        req = "R4";
        drive(1'b0, 24'h111111, 24'hFFFFFF, 8'd1); tick();
        chk("R4 floor of -1/256", longint'(phase_o), 64'hFFFFFF);
        drive(1'b0, 24'h111111, 24'd256, 8'd3); tick();
        chk("R4 256*3", longint'(phase_o), 3);
        drive(1'b0, 24'h111111, 24'h7FFFFF, 8'd255); tick();
        chk("R4 max positive", longint'(phase_o), 64'h7F7FFF);
        drive(1'b0, 24'h111111, 24'h800000, 8'd255); tick();
        chk("R8 max negative wraps", longint'(phase_o), 64'h808000);
        drive(1'b0, 24'h111111, 24'hFFFFFF, 8'd255); tick();
        chk("R4 -255/256", longint'(phase_o), 64'hFFFFFF);

        // R2/R7: pure carrier stepping through wrap.
        req = "R2";
        drive(1'b1, 24'h123456, 24'h0, 8'd200);
        repeat (40) tick();
        req = "R7";
        drive(1'b1, 24'hFFFFFF, 24'h345678, 8'd0);
        repeat (10) tick();

        // R3: carrier held while modulation keeps moving.
        req = "R3";
        for (int i = 0; i < 12; i++) begin
            drive(1'b0, 24'h0F0F0F, 24'(i * 24'h051234), 8'(i * 21));
            tick();
        end

        // R5: modulated carrier with varying inputs.
        req = "R5";
        for (int i = 0; i < 300; i++) begin
            drive(1'b1, 24'h0004D2 + 24'(i), 24'($urandom), 8'($urandom));
            tick();
        end

        // R6: modulation removed, carrier continues unaffected.
        req = "R6";
        drive(1'b1, 24'h0004D2, 24'h0, 8'd77);
        repeat (20) tick();

        // R5: random enable pattern with random inputs.
        req = "R5";
        for (int i = 0; i < 500; i++) begin
            drive(1'($urandom), 24'($urandom), 24'($urandom), 8'($urandom));
            tick();
        end

        // R1: reset in the middle of activity.
        req = "R1";
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        req = "R8";
        drive(1'b1, 24'h000010, 24'h800000, 8'd128);
        repeat (20) tick();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule